// File: doc/BRIEF.md
# Event Interrupter with Moderation Timer

This block is a single event interrupter for a host controller's event path. An event ring writer pulses `event_post` whenever it places a new event, which sets a pending flag. Software owns two registers: a management word, with a pending flag that software clears by writing 1 and an enable flag, and a moderation word. The moderation word holds a minimum interrupt interval and a countdown that hardware runs down in 250 ns steps, using a tick input from a 4 MHz time base.

An interrupt fires as a one-cycle pulse on `irq_o` when four things hold at once: the countdown is at zero, an event is pending, the interrupter is enabled, and the handler-busy flag is clear. At that moment the countdown reloads from the interval and handler-busy sets, so the next interrupt is held back by both the service handshake and the minimum spacing. When no event is pending, the gap between interrupts simply grows beyond the interval. Handler-busy can be read at bit 3 of select 2, and a pulse on `hbusy_ack` clears it.

Top module: `evt_intr_throttle`

## Requirements
- R1: After reset, the management word reads 0, the moderation word reads interval 4000 (0x0FA0) with countdown 0, the busy word reads 0, and `irq_o` is low.
- R2: A pulse on `event_post` sets the pending flag (select 0, bit 0). A management write with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. When a post and a clear fall in the same cycle, the flag ends up set.
- R3: A management write stores bit 1 as the enable flag, which reads back at select 0, bit 1. This write does not set the pending flag.
- R4: A moderation write (select 1) loads the interval from bits 15:0 and the countdown from bits 31:16. Both read back in the same positions.
- R5: The countdown drops by one on each cycle in which `tick` is high, holds when `tick` is low, and stays at zero once it gets there.
- R6: `irq_o` goes high for exactly one cycle, in the cycle after a clock edge at which the countdown is zero, pending is set, enable is set and handler-busy is clear. It never goes high otherwise.
- R7: When an interrupt fires, handler-busy (select 2, bit 3) sets and the countdown reloads from the interval. A moderation write in that same cycle takes priority for the countdown.
- R8: While handler-busy is set, no interrupt fires. A pulse on `hbusy_ack` clears it, and the next interrupt then still waits for the countdown to reach zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 250 ns time-base pulse |
| event_post | input | 1 | New event placed on the ring |
| hbusy_ack | input | 1 | Software has serviced the interrupt; clears handler-busy |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 management, 1 moderation |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 management, 1 moderation, 2 busy |
| rd_data | output | 32 | Read data for `rd_sel` (combinational) |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The assertions take the following for granted: `tick` is a single-cycle strobe, and `hbusy_ack` and `event_post` are level inputs sampled at each edge with no ordering between them. They also rely on the countdown decrement being checked only when no moderation write happens in that cycle. The random stimulus drives every input once per cycle at the falling edge, so every combination of post, acknowledge, tick and write can occur, including a write landing in the same cycle as an interrupt. Moderation values are kept small so that countdown expiry and reloads happen often within the run.

// File: rtl/evt_intr_throttle.sv
module evt_intr_throttle #(
  parameter int unsigned IVL_W   = 16,
  parameter int unsigned RST_IVL = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              event_post,
  input  logic              hbusy_ack,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [2*IVL_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [2*IVL_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int unsigned DW = 2*IVL_W;
  localparam logic [1:0] SEL_MGMT = 2'd0;
  localparam logic [1:0] SEL_MOD  = 2'd1;
  localparam logic [1:0] SEL_BUSY = 2'd2;
  localparam int unsigned BUSY_BIT = 3;

  logic             pend_q, en_q, busy_q;
  logic [IVL_W-1:0] ivl_q, cnt_q;

  wire wr_mgmt = wr_en && (wr_sel == SEL_MGMT);
  wire wr_mod  = wr_en && (wr_sel == SEL_MOD);
  wire cnt_zero = (cnt_q == '0);
  wire fire = pend_q && en_q && !busy_q && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      ivl_q  <= IVL_W'(RST_IVL);
      cnt_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= event_post || (pend_q && !(wr_mgmt && wr_data[0]));
      if (wr_mgmt) en_q <= wr_data[1];
      if (wr_mod) ivl_q <= wr_data[IVL_W-1:0];
      if (wr_mod)
        cnt_q <= wr_data[DW-1:IVL_W];
      else if (fire)
        cnt_q <= ivl_q;
      else if (tick && !cnt_zero)
        cnt_q <= cnt_q - 1'b1;
      if (fire)
        busy_q <= 1'b1;
      else if (hbusy_ack)
        busy_q <= 1'b0;
      irq_o <= fire;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_MGMT: rd_data[1:0] = {en_q, pend_q};
      SEL_MOD:  rd_data = {cnt_q, ivl_q};
      SEL_BUSY: rd_data[BUSY_BIT] = busy_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

module evt_intr_throttle_chk #(
  parameter int unsigned IVL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             event_post,
  input logic             hbusy_ack,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             irq_o,
  input logic             pend,
  input logic             en,
  input logic             busy,
  input logic [IVL_W-1:0] cnt,
  input logic [IVL_W-1:0] ivl
);
  wire mod_wr = wr_en && (wr_sel == 2'd1);

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    event_post |=> pend);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pend && en && !busy && cnt == '0));

  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> busy);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(mod_wr)) |-> (cnt == ivl));

  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !mod_wr) |=> (cnt == $past(cnt) - 1'b1));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !mod_wr && busy) |=> $stable(cnt));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hbusy_ack) |=> busy);

  p_no_irq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !irq_o);
endmodule

bind evt_intr_throttle evt_intr_throttle_chk #(.IVL_W(IVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .event_post(event_post),
  .hbusy_ack(hbusy_ack), .wr_en(wr_en), .wr_sel(wr_sel), .irq_o(irq_o),
  .pend(pend_q), .en(en_q), .busy(busy_q), .cnt(cnt_q), .ivl(ivl_q)
);

// File: tb/evt_intr_throttle_tb.sv
`timescale 1ns/1ps
module evt_intr_throttle_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, event_post = 1'b0, hbusy_ack = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic        m_pend, m_en, m_busy, m_irq;
  logic [15:0] m_ivl, m_cnt;

  always #2.5 clk = ~clk;

  evt_intr_throttle u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .event_post(event_post),
    .hbusy_ack(hbusy_ack), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: m_read = {30'd0, m_en, m_pend};
      2'd1: m_read = {m_cnt, m_ivl};
      2'd2: m_read = {28'd0, m_busy, 3'd0};
      default: m_read = '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    for (int s = 0; s < 3; s++) begin
      rd_sel = 2'(s);
      #0.2;
      chk({tag, " read"}, rd_data, m_read(2'(s)));
    end
  endtask

  task automatic step(input logic post, input logic ack, input logic tk,
                      input logic we, input logic [1:0] ws, input logic [31:0] wd);
    logic fire, n_pend, n_en, n_busy;
    logic [15:0] n_ivl, n_cnt;
    @(negedge clk);
    event_post = post; hbusy_ack = ack; tick = tk;
    wr_en = we; wr_sel = ws; wr_data = wd;
    fire   = m_pend && m_en && !m_busy && (m_cnt == 16'd0);
    n_pend = post || (m_pend && !(we && ws == 2'd0 && wd[0]));
    n_en   = (we && ws == 2'd0) ? wd[1] : m_en;
    n_ivl  = (we && ws == 2'd1) ? wd[15:0] : m_ivl;
    if (we && ws == 2'd1) n_cnt = wd[31:16];
    else if (fire) n_cnt = m_ivl;
    else if (tk && m_cnt != 16'd0) n_cnt = m_cnt - 16'd1;
    else n_cnt = m_cnt;
    n_busy = fire ? 1'b1 : (ack ? 1'b0 : m_busy);
    @(posedge clk);
    #1;
    m_pend = n_pend; m_en = n_en; m_ivl = n_ivl; m_cnt = n_cnt;
    m_busy = n_busy; m_irq = fire;
  endtask

  task automatic idle(input logic tk);
    step(1'b0, 1'b0, tk, 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pend = 0; m_en = 0; m_busy = 0; m_irq = 0; m_ivl = 16'd4000; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state, explicit values
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd_sel = 2'd0; #0.2; chk("R1 mgmt", rd_data, 32'h0);
    rd_sel = 2'd1; #0.2; chk("R1 moderation", rd_data, 32'h0000_0FA0);
    rd_sel = 2'd2; #0.2; chk("R1 busy", rd_data, 32'h0);

    // R4 moderation load
    step(0, 0, 0, 1, 2'd1, {16'd3, 16'd5});
    rd_sel = 2'd1; #0.2; chk("R4 moderation", rd_data, {16'd3, 16'd5});
    // R5 hold without tick, decrement, saturate
    idle(1'b0); chk_all("R5 hold");
    repeat (3) begin idle(1'b1); chk_all("R5 dec"); end
    rd_sel = 2'd1; #0.2; chk("R5 at zero", rd_data[31:16], 32'd0);
    idle(1'b1); chk_all("R5 saturate");
    // R2 pending set and write-1-to-clear
    step(1, 0, 0, 0, 2'd0, 32'd0); chk_all("R2 post");
    step(0, 0, 0, 1, 2'd0, 32'd0); chk_all("R2 write0 keeps");
    rd_sel = 2'd0; #0.2; chk("R2 pend kept", rd_data, 32'h1);
    step(0, 0, 0, 1, 2'd0, 32'd1); chk_all("R2 clear");
    rd_sel = 2'd0; #0.2; chk("R2 pend cleared", rd_data, 32'h0);
    step(1, 0, 0, 1, 2'd0, 32'd1); chk_all("R2 post wins");
    // R3 enable, then R6 fire and R7 reload
    step(0, 0, 0, 1, 2'd0, 32'd2); chk_all("R3 enable");
    rd_sel = 2'd0; #0.2; chk("R3 mgmt", rd_data, 32'h3);
    idle(1'b0); chk_all("R6 fire");
    chk("R6 irq high", {31'd0, irq_o}, 32'd1);
    rd_sel = 2'd2; #0.2; chk("R7 busy", rd_data, 32'h8);
    rd_sel = 2'd1; #0.2; chk("R7 reload", rd_data, {16'd5, 16'd5});
    idle(1'b0); chk_all("R6 one cycle");
    // R8 busy blocks even at zero count
    repeat (7) begin idle(1'b1); chk_all("R8 blocked"); end
    step(0, 1, 0, 0, 2'd0, 32'd0); chk_all("R8 ack");
    idle(1'b0); chk_all("R8 refire");
    chk("R8 irq after ack", {31'd0, irq_o}, 32'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we, po, ak, tk;
      logic [1:0] ws;
      logic [31:0] wd;
      po = ($urandom % 8) == 0;
      ak = ($urandom % 6) == 0;
      tk = ($urandom % 3) == 0;
      we = ($urandom % 10) == 0;
      ws = 2'($urandom % 3);
      if (ws == 2'd1) wd = {16'($urandom % 12), 16'($urandom % 10)};
      else wd = {30'd0, ($urandom % 5) != 0, 1'($urandom)};
      step(po, ak, tk, we, ws, wd);
      chk_all("R6 R7 R8 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule